// File: doc/BRIEF.md
# Black Level Calibration Controller

This controller keeps the black level of a video readout path on target by trimming two 8-bit offset DAC codes: a fine code (B0, one code per LSB of error) and a coarse code (B1, one code per four LSB of error). It watches the pixel stream using the line and column indices supplied by the timing logic. Once per field, on monitor line 2, it averages a group of sixteen black reference pixels and compares the average with a programmable window. An average outside the window arms a recalibration.

A recalibration can also be requested by a gain-change pulse or a force pulse from the serial interface. A request that arrives after the monitor decision of the current field waits as pending until the next field's decision. Once armed, the block runs three phases of two lines each over lines 3 to 8. The first phase trims B0 while the analog path is told to present common-mode data. The second phase trims B1. The third phase trims B0 again, this time on black reference pixels. Each phase measures its own line's pixel group and moves its code by a step derived from (target − average), saturating at 0 and 255.

Top module: `blc_ctrl`

## Requirements
- R1: After reset, b0_code and b1_code are 128, and busy, cm_sel and recal_flag are 0.
- R2: Only pixels with pix_valid high on the sampling line and columns 130 to 145 are used when grp_alt is 0. When grp_alt is 1, columns 114 to 129 are used. Pixels at any other column have no effect on the average.
- R3: On line 2 the average is the sum of the 16 group samples shifted right by 4. recal_flag rises at the clock edge that takes the 16th sample if the average is below thr_lo or above thr_hi. An average inside the window, bounds included, arms nothing.
- R4: A gain_chg or force_cal pulse that arrives no later than the 16th monitor sample of line 2 arms an update in the same field, whatever the average. A pulse that arrives later is held and arms the update at the next field's decision.
- R5: When armed, busy rises at the first clock of line 3 and falls at the first clock of line 9. recal_flag clears as busy rises. cm_sel is high only during lines 3 and 4 of an update.
- R6: At the 16th group sample of line 3 and of line 7, B0 moves by (thr target − average). At the 16th group sample of line 5, B1 moves by (target − average) arithmetically shifted right by 2, which rounds toward minus infinity. B1 changes at no other time.
- R7: Both codes saturate at 0 and 255 instead of wrapping.
- R8: While busy is low, neither DAC code changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pix_valid | input | 1 | pix_data holds a pixel sample |
| pix_data | input | 8 | Pixel sample from the ADC |
| line_idx | input | 8 | Current line within the field, 0 at field start |
| col_idx | input | 8 | Current column of pix_data |
| gain_chg | input | 1 | One-cycle pulse: analog gain changed |
| force_cal | input | 1 | One-cycle pulse: recalibration requested by software |
| grp_alt | input | 1 | 0: last 16-pixel group of the middle 128; 1: the group before it |
| thr_lo | input | 8 | Lower bound of the accepted black window |
| thr_hi | input | 8 | Upper bound of the accepted black window |
| target | input | 8 | Black level the update aims for |
| b0_code | output | 8 | Fine offset DAC code |
| b1_code | output | 8 | Coarse offset DAC code |
| busy | output | 1 | Update phases in progress |
| cm_sel | output | 1 | Analog path should present common-mode data |
| recal_flag | output | 1 | Update armed for the coming line 3 |

## Verification
The hardest situation to reach from the ports is a request pulse that lands right at the monitor decision. If it lands on the very sample that completes the line-2 group, it must arm the current field. If it lands one column later, it must wait a whole field. The stimulus places pulses at exactly those columns, and also inside a running update. A behavioural offset plant produces the black pixels from the bench's own code prediction, so that each phase's error depends on the earlier phases. Targets pinned at the extremes drive both codes into saturation from either side.

// File: rtl/blc_pkg.sv
package blc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PH1  = 2'd1,
    ST_PH2  = 2'd2,
    ST_PH3  = 2'd3
  } blc_state_e;
endpackage

// File: rtl/blc_accum.sv
module blc_accum #(
  parameter int DW       = 8,
  parameter int GRP_LOG2 = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          smp_en,
  input  logic [DW-1:0] smp,
  output logic          avg_vld,
  output logic [DW-1:0] avg
);
  localparam int SW  = DW + GRP_LOG2;
  localparam int GRP = 1 << GRP_LOG2;

  logic [SW-1:0]       sum_q, sum_n, sum_add;
  logic [GRP_LOG2-1:0] cnt_q, cnt_n, cnt_base;

  always_comb begin
    sum_add  = (clr ? '0 : sum_q) + SW'(smp);
    cnt_base = clr ? '0 : cnt_q;
    sum_n    = clr ? '0 : sum_q;
    cnt_n    = cnt_base;
    avg_vld  = 1'b0;
    if (smp_en) begin
      if (cnt_base == GRP_LOG2'(GRP - 1)) begin
        avg_vld = 1'b1;
        sum_n   = '0;
        cnt_n   = '0;
      end else begin
        sum_n = sum_add;
        cnt_n = cnt_base + 1'b1;
      end
    end
  end

  assign avg = sum_add[SW-1:GRP_LOG2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else begin
      sum_q <= sum_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/blc_trim.sv
module blc_trim #(
  parameter int DW       = 8,
  parameter int EW       = 10,
  parameter int SHIFT    = 0,
  parameter int RST_CODE = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 apply,
  input  logic signed [EW-1:0] err,
  output logic [DW-1:0]        code
);
  logic signed [EW-1:0] step, tot;
  logic [DW-1:0]        code_q, code_n;

  always_comb begin
    step   = err >>> SHIFT;
    tot    = $signed({{(EW-DW){1'b0}}, code_q}) + step;
    code_n = code_q;
    if (apply) begin
      if (tot < 0)
        code_n = '0;
      else if (tot > $signed({{(EW-DW){1'b0}}, {DW{1'b1}}}))
        code_n = {DW{1'b1}};
      else
        code_n = tot[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= DW'(RST_CODE);
    else        code_q <= code_n;
  end

  assign code = code_q;
endmodule

// File: rtl/blc_seq.sv
module blc_seq
  import blc_pkg::*;
#(
  parameter int LW        = 8,
  parameter int UPD_FIRST = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] line_idx,
  input  logic          avg_vld,
  input  logic          miss,
  input  logic          trig,
  output blc_state_e    state,
  output logic          armed,
  output logic          pend
);
  blc_state_e st_q, st_n;
  logic       arm_q, arm_n, pend_q, pend_n, decide;

  assign decide = (st_q == ST_IDLE) && avg_vld;

  always_comb begin
    st_n   = st_q;
    arm_n  = arm_q;
    pend_n = decide ? 1'b0 : (pend_q | trig);
    if (decide) arm_n = miss | pend_q | trig;
    case (st_q)
      ST_IDLE: if (arm_q && line_idx == LW'(UPD_FIRST)) begin
        st_n  = ST_PH1;
        arm_n = 1'b0;
      end
      ST_PH1: if (line_idx == LW'(UPD_FIRST + 2)) st_n = ST_PH2;
      ST_PH2: if (line_idx == LW'(UPD_FIRST + 4)) st_n = ST_PH3;
      ST_PH3: if (line_idx == LW'(UPD_FIRST + 6)) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      arm_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      arm_q  <= arm_n;
      pend_q <= pend_n;
    end
  end

  assign state = st_q;
  assign armed = arm_q;
  assign pend  = pend_q;

  // R4: a request outside the decision sample is kept pending
  p_trig_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !decide) |=> pend_q);

  // R5: phases advance strictly in order
  p_phase_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PH2) |-> ($past(st_q) == ST_PH1 || $past(st_q) == ST_PH2));
endmodule

// File: rtl/blc_ctrl.sv
module blc_ctrl
  import blc_pkg::*;
#(
  parameter int DW           = 8,
  parameter int LW           = 8,
  parameter int CW           = 8,
  parameter int LINE_PIX     = 164,
  parameter int MID_PIX      = 128,
  parameter int GRP_LOG2     = 4,
  parameter int MON_LINE     = 2,
  parameter int UPD_FIRST    = 3,
  parameter int COARSE_SHIFT = 2,
  parameter int DAC_RST      = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic [DW-1:0] pix_data,
  input  logic [LW-1:0] line_idx,
  input  logic [CW-1:0] col_idx,
  input  logic          gain_chg,
  input  logic          force_cal,
  input  logic          grp_alt,
  input  logic [DW-1:0] thr_lo,
  input  logic [DW-1:0] thr_hi,
  input  logic [DW-1:0] target,
  output logic [DW-1:0] b0_code,
  output logic [DW-1:0] b1_code,
  output logic          busy,
  output logic          cm_sel,
  output logic          recal_flag
);
  localparam int GRP       = 1 << GRP_LOG2;
  localparam int MID_START = (LINE_PIX - MID_PIX) / 2;
  localparam int GRP_LAST  = MID_START + MID_PIX - GRP;
  localparam int GRP_PREV  = GRP_LAST - GRP;
  localparam int EW        = DW + 2;

  blc_state_e           state;
  logic [LW-1:0]        line_q, samp_line;
  logic [CW-1:0]        grp_start;
  logic                 line_chg, in_grp, smp_en, avg_vld, miss, trig, armed, pend;
  logic [DW-1:0]        avg;
  logic signed [EW-1:0] err;
  logic [1:0]           apply;
  logic [DW-1:0]        codes [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_idx;
  end

  always_comb begin
    line_chg  = (line_idx != line_q);
    grp_start = grp_alt ? CW'(GRP_PREV) : CW'(GRP_LAST);
    in_grp    = (col_idx >= grp_start) && (col_idx < grp_start + CW'(GRP));
    case (state)
      ST_PH1:  samp_line = LW'(UPD_FIRST);
      ST_PH2:  samp_line = LW'(UPD_FIRST + 2);
      ST_PH3:  samp_line = LW'(UPD_FIRST + 4);
      default: samp_line = LW'(MON_LINE);
    endcase
    smp_en = pix_valid && in_grp && (line_idx == samp_line);
    miss   = (avg < thr_lo) || (avg > thr_hi);
    trig   = gain_chg | force_cal;
    err    = $signed({2'b00, target}) - $signed({2'b00, avg});
    apply[0] = avg_vld && (state == ST_PH1 || state == ST_PH3);
    apply[1] = avg_vld && (state == ST_PH2);
  end

  blc_accum #(.DW(DW), .GRP_LOG2(GRP_LOG2)) u_accum (
    .clk(clk), .rst_n(rst_n), .clr(line_chg), .smp_en(smp_en), .smp(pix_data),
    .avg_vld(avg_vld), .avg(avg)
  );

  blc_seq #(.LW(LW), .UPD_FIRST(UPD_FIRST)) u_seq (
    .clk(clk), .rst_n(rst_n), .line_idx(line_idx), .avg_vld(avg_vld),
    .miss(miss), .trig(trig), .state(state), .armed(armed), .pend(pend)
  );

  for (genvar g = 0; g < 2; g++) begin : g_dac
    localparam int SH = (g == 0) ? 0 : COARSE_SHIFT;
    blc_trim #(.DW(DW), .EW(EW), .SHIFT(SH), .RST_CODE(DAC_RST)) u_trim (
      .clk(clk), .rst_n(rst_n), .apply(apply[g]), .err(err), .code(codes[g])
    );
  end

  assign b0_code    = codes[0];
  assign b1_code    = codes[1];
  assign busy       = (state != ST_IDLE);
  assign cm_sel     = (state == ST_PH1);
  assign recal_flag = armed;

  // R8: codes hold while no update runs
  p_dac_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(b0_code) && $stable(b1_code)));

  // R6: coarse code moves only in its own phase
  p_b1_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_PH2) |=> $stable(b1_code));

  // R5: update starts on the first update line and consumes the arm flag
  p_busy_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(line_idx) == LW'(UPD_FIRST) && !recal_flag));
endmodule

// File: tb/blc_ctrl_tb.sv
module blc_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_valid = 1'b0;
  logic [7:0] pix_data = '0, line_idx = '0, col_idx = '0;
  logic       gain_chg = 1'b0, force_cal = 1'b0, grp_alt = 1'b0;
  logic [7:0] thr_lo = 8'd0, thr_hi = 8'd255, target = 8'd16;
  logic [7:0] b0_code, b1_code;
  logic       busy, cm_sel, recal_flag;

  always #2 clk = ~clk;

  blc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .line_idx(line_idx), .col_idx(col_idx), .gain_chg(gain_chg), .force_cal(force_cal),
    .grp_alt(grp_alt), .thr_lo(thr_lo), .thr_hi(thr_hi), .target(target),
    .b0_code(b0_code), .b1_code(b1_code), .busy(busy), .cm_sel(cm_sel),
    .recal_flag(recal_flag)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int eb0 = 128, eb1 = 128;
  bit pend = 0, late = 0, run = 0;
  int base = 16, cm_base = 16;
  string b0_tag = "R6";

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v < 0) ? 0 : (v > 255) ? 255 : v;
  endfunction

  // one field of 10 lines; pulse kind 0=gain 1=force at (tl,tc), tl<0 none
  task automatic run_field(input int tl, input int tc, input bit kind);
    int gs, dec_col;
    gs = grp_alt ? 114 : 130;
    dec_col = gs + 15;
    for (int l = 0; l < 10; l++) begin
      int sum, avg;
      sum = 0;
      for (int c = 0; c < 168; c++) begin
        @(negedge clk);
        line_idx  = 8'(l);
        col_idx   = 8'(c);
        pix_valid = (c < 164);
        gain_chg  = 1'b0;
        force_cal = 1'b0;
        if (c >= gs && c <= dec_col) begin
          int v, nz;
          nz = int'($urandom_range(0, 6)) - 3;
          if (run && (l == 3 || l == 4)) v = sat(cm_base + eb0 - 128 + nz);
          else v = sat(base + eb0 - 128 + 4 * (eb1 - 128) + nz);
          pix_data = 8'(v);
          sum += v;
        end else begin
          pix_data = 8'($urandom_range(0, 255));
        end
        if (l == tl && c == tc) begin
          if (kind) force_cal = 1'b1; else gain_chg = 1'b1;
          if (l < 2 || (l == 2 && c <= dec_col)) pend = 1; else late = 1;
        end
      end
      @(negedge clk);
      gain_chg = 1'b0; force_cal = 1'b0; pix_valid = 1'b0;
      avg = sum >> 4;
      if (l == 2) begin
        bit arm;
        arm = (avg < int'(thr_lo)) || (avg > int'(thr_hi)) || pend;
        chk("R3 recal_flag after line 2 decision", int'(recal_flag), int'(arm));
        pend = late; late = 0; run = arm;
      end else begin
        pend = pend | late; late = 0;
      end
      if (run && (l == 3 || l == 7)) eb0 = sat(eb0 + (int'(target) - avg));
      if (run && l == 5) eb1 = sat(eb1 + ((int'(target) - avg) >>> 2));
      chk("R5 busy at line end", int'(busy), int'(run && l >= 3 && l <= 8));
      chk("R5 cm_sel at line end", int'(cm_sel), int'(run && (l == 3 || l == 4)));
      chk(run ? b0_tag : "R8", int'(b0_code), eb0);
      chk(run ? "R6 b1" : "R8 b1", int'(b1_code), eb1);
      if (l == 9) run = 0;
    end
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk("R1 b0 reset", int'(b0_code), 128);
    chk("R1 b1 reset", int'(b1_code), 128);
    chk("R1 busy reset", int'(busy), 0);
    chk("R1 cm_sel reset", int'(cm_sel), 0);
    chk("R1 recal_flag reset", int'(recal_flag), 0);
    rst_n = 1'b1;
    // in-window, no trigger: nothing moves (R3, R8)
    thr_lo = 8'd0; thr_hi = 8'd255; target = 8'd40; base = 20; cm_base = 60;
    run_field(-1, 0, 0);
    // tight window misses: full update (R3, R6)
    thr_lo = 8'd38; thr_hi = 8'd42;
    run_field(-1, 0, 0);
    run_field(-1, 0, 0);
    // R4: force before decision, window wide
    thr_lo = 8'd0; thr_hi = 8'd255; target = 8'd90;
    run_field(1, 20, 1);
    // R4: gain change in mid-field, then serviced next field
    run_field(6, 10, 0);
    run_field(-1, 0, 0);
    // R4: exactly on the decision sample, then one column late
    run_field(2, 145, 1);
    run_field(2, 146, 0);
    run_field(-1, 0, 0);
    // R4: request during a running update is held
    run_field(4, 50, 1);
    run_field(-1, 0, 0);
    // R2: alternate group, garbage elsewhere
    grp_alt = 1'b1; target = 8'd70; thr_lo = 8'd69; thr_hi = 8'd71;
    run_field(-1, 0, 0);
    run_field(2, 129, 0);
    grp_alt = 1'b0;
    // R7: saturation high then low
    b0_tag = "R7"; target = 8'd255; base = 0; cm_base = 0; thr_lo = 8'd200; thr_hi = 8'd255;
    run_field(-1, 0, 0);
    run_field(-1, 0, 0);
    target = 8'd0; base = 250; cm_base = 250; thr_lo = 8'd0; thr_hi = 8'd5;
    run_field(-1, 0, 0);
    run_field(-1, 0, 0);
    b0_tag = "R6";
    // constrained random fields
    for (int f = 0; f < 16; f++) begin
      int tl, tc;
      target  = 8'($urandom_range(10, 240));
      base    = int'($urandom_range(0, 255));
      cm_base = int'($urandom_range(0, 255));
      thr_lo  = 8'($urandom_range(0, 120));
      thr_hi  = 8'($urandom_range(120, 255));
      grp_alt = 1'($urandom_range(0, 1));
      tl = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 9)) : -1;
      tc = int'($urandom_range(100, 167));
      run_field(tl, tc, 1'($urandom_range(0, 1)));
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule